// File: doc/BRIEF.md
# Parity-Checked Direct-Mapped Instruction Cache

This block is a read-only, direct-mapped instruction cache. Every line has a tag entry and one data granule. Both are stored with a single even-parity bit, which is generated when a line is refilled and checked on every lookup. The next memory level behind the cache is reached through a refill request/response port. A test port can flip any stored bit, including a parity bit, so that the recovery path can be exercised.

A lookup that finds a parity mismatch in a valid line's tag, or in the data of a line whose tag matches, does not raise a fault. The cache clears that line's valid bit and takes the normal miss path: it issues a refill request, waits for the response, writes the line back with fresh parity, and returns the refilled word. A one-cycle pulse marks each access that was recovered this way. The parity check sits beside the tag compare in the lookup stage, so a clean hit takes exactly as many cycles as it would without protection.

Only one access is in flight at a time. While a lookup or refill is pending, the fetch port is not ready, so a fetch that targets the line being refilled waits until that refill has completed. A double flip inside one granule leaves the parity unchanged, and the cache returns the corrupted word as an ordinary hit.

Top module: `icache_parity_top`

## Requirements
- R1: After reset, `fetch_req_ready` is 1, `fetch_rsp_valid`, `refill_req_valid` and `err_refetch` are 0, and no line is valid, so the first fetch to any address misses.
- R2: A fetch accepted at rising edge k that hits a clean line raises `fetch_rsp_valid` for exactly one cycle after edge k+1, with the stored word on `fetch_rsp_data`, and issues no refill request.
- R3: On refill, the tag (the upper TAG_W address bits) and the data word are each stored with an even-parity bit, so that the stored parity makes the XOR of each stored entry zero. A freshly refilled line then hits without an error.
- R4: A fetch that misses raises `refill_req_valid` for one cycle after edge k+1, with `refill_req_addr` equal to the fetch address. The lower IDX_W address bits select the line.
- R5: A `refill_rsp_valid` received while waiting writes the line and marks it valid. `fetch_rsp_data` then returns the refill word in the cycle after that edge, and a later fetch to the same address hits.
- R6: A single flipped bit in a valid line's stored tag is treated as a miss. The line is refetched, the correct word is returned, `err_refetch` pulses with that response, and the next fetch to the line hits cleanly.
- R7: A single flipped bit in the stored data of a line whose tag matches is handled the same way as in R6: refetch, correct word, `err_refetch` pulse, then clean hits.
- R8: `err_refetch` is a one-cycle pulse that occurs only together with `fetch_rsp_valid`, and only for accesses recovered from a parity error, never for plain misses.
- R9: From acceptance until the response, `fetch_req_ready` stays 0, so no other fetch (including one to the line under refill) is accepted.
- R10: Two flipped bits in one data granule are not detected. The fetch is a normal hit that returns the corrupted word, with no refill request and no `err_refetch`.
- R11: Single-bit errors in different lines are recovered independently, one refetch and one pulse each, and lines without errors keep hitting.
- R12: `refill_rsp_valid` while no refill is pending is ignored. It produces no response and changes no stored line.
- R13: Injection: `inj_target` selects 0 for tag and 1 for data. Bit i of `inj_mask` flips stored bit i, and bit TAG_W (tag) or DATA_W (data) flips the parity bit. A flip of the parity bit alone is detected like any other single-bit error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req_valid | input | 1 | Fetch request present |
| fetch_req_addr | input | ADDR_W (35) | Word address: tag in the upper bits, line index in the lower IDX_W bits |
| fetch_req_ready | output | 1 | Fetch can be accepted this cycle |
| fetch_rsp_valid | output | 1 | One-cycle fetch response strobe |
| fetch_rsp_data | output | DATA_W (72) | Fetched word |
| refill_req_valid | output | 1 | One-cycle refill request strobe |
| refill_req_addr | output | ADDR_W (35) | Address to refill |
| refill_rsp_valid | input | 1 | Refill data present |
| refill_rsp_data | input | DATA_W (72) | Refill word |
| inj_valid | input | 1 | Apply an injection mask this cycle |
| inj_target | input | 1 | 0 selects the tag array, 1 selects the data array |
| inj_index | input | IDX_W (4) | Line whose stored entry is flipped |
| inj_mask | input | DATA_W+1 (73) | XOR mask over the stored bits and the parity bit |
| err_refetch | output | 1 | Pulse: this response was recovered from a parity error |

## Verification
On every cycle the assertions check that response, refill-request and error strobes last one cycle, that an error pulse always comes with a response, that the fetch port is closed while a refill is outstanding, and that every array write leaves an entry with even parity and a set valid bit. Only the directed scenarios can show the behaviour that depends on data. These include the hit and miss latencies, that a flipped tag, data or parity bit leads to exactly one refetch and returns the correct word, that a double flip passes undetected, that errors in separate lines are recovered independently, and that a stray refill response is ignored.

// File: rtl/icp_pkg.sv
package icp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_WAIT   = 2'd2
  } icp_state_e;

  typedef enum logic {
    INJ_TAG  = 1'b0,
    INJ_DATA = 1'b1
  } icp_inj_e;
endpackage

// File: rtl/icp_parity_array.sv
module icp_parity_array #(
  parameter int W     = 72,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_bits,
  output logic          rd_par_err,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_bits,
  input  logic          inj_en,
  input  logic [AW-1:0] inj_addr,
  input  logic [W:0]    inj_mask
);
  // Each entry: {parity, payload}; even parity over the whole entry.
  logic [W:0] mem [DEPTH];
  logic [W:0] rd_word;

  always_ff @(posedge clk) begin
    if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    if (wr_en)  mem[wr_addr]  <= {^wr_bits, wr_bits};
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_word <= '0;
    else if (rd_en) rd_word <= mem[rd_addr];
  end

  assign rd_bits    = rd_word[W-1:0];
  assign rd_par_err = ^rd_word;

  AST_WRITE_PARITY: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((^mem[$past(wr_addr)]) == 1'b0)); // R3
endmodule

// File: rtl/icp_ctrl.sv
module icp_ctrl
  import icp_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int TAG_W  = 31,
  parameter int DATA_W = 72,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req_valid,
  input  logic [ADDR_W-1:0] fetch_req_addr,
  output logic              fetch_req_ready,
  output logic              fetch_rsp_valid,
  output logic [DATA_W-1:0] fetch_rsp_data,
  output logic              refill_req_valid,
  output logic [ADDR_W-1:0] refill_req_addr,
  input  logic              refill_rsp_valid,
  input  logic [DATA_W-1:0] refill_rsp_data,
  output logic              err_refetch,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  tag_rd_bits,
  input  logic              tag_par_err,
  input  logic [DATA_W-1:0] data_rd_bits,
  input  logic              data_par_err,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);
  icp_state_e        state_q;
  logic [LINES-1:0]  line_valid;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;
  logic              err_q;

  logic accept, tag_match, hit, fault;

  assign fetch_req_ready = (state_q == ST_IDLE);
  assign accept          = fetch_req_valid && fetch_req_ready;
  assign rd_en           = accept;
  assign rd_idx          = fetch_req_addr[IDX_W-1:0];

  // Lookup stage: parity check sits beside the tag compare.
  assign tag_match = (tag_rd_bits == addr_q[ADDR_W-1:IDX_W]);
  assign hit       = valid_q && !tag_par_err && tag_match && !data_par_err;
  assign fault     = valid_q && (tag_par_err || (tag_match && data_par_err));

  assign wr_en   = (state_q == ST_WAIT) && refill_rsp_valid;
  assign wr_idx  = addr_q[IDX_W-1:0];
  assign wr_tag  = addr_q[ADDR_W-1:IDX_W];
  assign wr_data = refill_rsp_data;

  assign refill_req_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q          <= ST_IDLE;
      line_valid       <= '0;
      addr_q           <= '0;
      valid_q          <= 1'b0;
      err_q            <= 1'b0;
      fetch_rsp_valid  <= 1'b0;
      fetch_rsp_data   <= '0;
      refill_req_valid <= 1'b0;
      err_refetch      <= 1'b0;
    end else begin
      fetch_rsp_valid  <= 1'b0;
      refill_req_valid <= 1'b0;
      err_refetch      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= fetch_req_addr;
            valid_q <= line_valid[rd_idx];
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit) begin
            fetch_rsp_valid <= 1'b1;
            fetch_rsp_data  <= data_rd_bits;
            state_q         <= ST_IDLE;
          end else begin
            line_valid[addr_q[IDX_W-1:0]] <= 1'b0;
            err_q            <= fault;
            refill_req_valid <= 1'b1;
            state_q          <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (refill_rsp_valid) begin
            line_valid[addr_q[IDX_W-1:0]] <= 1'b1;
            fetch_rsp_valid <= 1'b1;
            fetch_rsp_data  <= refill_rsp_data;
            err_refetch     <= err_q;
            state_q         <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fetch_rsp_valid |=> !fetch_rsp_valid); // R2
  AST_REFILL_PULSE: assert property (@(posedge clk) disable iff (rst)
    refill_req_valid |=> !refill_req_valid); // R4
  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> line_valid[$past(wr_idx)]); // R5
  AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
    err_refetch |-> fetch_rsp_valid); // R8
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    err_refetch |=> !err_refetch); // R8
  AST_STALL_IN_REFILL: assert property (@(posedge clk) disable iff (rst)
    refill_req_valid |-> !fetch_req_ready); // R9
endmodule

// File: rtl/icache_parity_top.sv
module icache_parity_top
  import icp_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int TAG_W  = 31,
  parameter int DATA_W = 72,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req_valid,
  input  logic [ADDR_W-1:0] fetch_req_addr,
  output logic              fetch_req_ready,
  output logic              fetch_rsp_valid,
  output logic [DATA_W-1:0] fetch_rsp_data,
  output logic              refill_req_valid,
  output logic [ADDR_W-1:0] refill_req_addr,
  input  logic              refill_rsp_valid,
  input  logic [DATA_W-1:0] refill_rsp_data,
  input  logic              inj_valid,
  input  logic              inj_target,
  input  logic [IDX_W-1:0]  inj_index,
  input  logic [DATA_W:0]   inj_mask,
  output logic              err_refetch
);
  logic              rd_en, wr_en;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [TAG_W-1:0]  tag_rd_bits, wr_tag;
  logic [DATA_W-1:0] data_rd_bits, wr_data;
  logic              tag_par_err, data_par_err;
  logic              inj_tag_en, inj_data_en;

  assign inj_tag_en  = inj_valid && (inj_target == INJ_TAG);
  assign inj_data_en = inj_valid && (inj_target == INJ_DATA);

  icp_ctrl #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_ctrl (
    .clk, .rst,
    .fetch_req_valid, .fetch_req_addr, .fetch_req_ready,
    .fetch_rsp_valid, .fetch_rsp_data,
    .refill_req_valid, .refill_req_addr,
    .refill_rsp_valid, .refill_rsp_data,
    .err_refetch,
    .rd_en, .rd_idx,
    .tag_rd_bits, .tag_par_err,
    .data_rd_bits, .data_par_err,
    .wr_en, .wr_idx, .wr_tag, .wr_data
  );

  icp_parity_array #(.W(TAG_W), .DEPTH(LINES)) i_tag_array (
    .clk, .rst,
    .rd_en, .rd_addr(rd_idx), .rd_bits(tag_rd_bits), .rd_par_err(tag_par_err),
    .wr_en, .wr_addr(wr_idx), .wr_bits(wr_tag),
    .inj_en(inj_tag_en), .inj_addr(inj_index), .inj_mask(inj_mask[TAG_W:0])
  );

  icp_parity_array #(.W(DATA_W), .DEPTH(LINES)) i_data_array (
    .clk, .rst,
    .rd_en, .rd_addr(rd_idx), .rd_bits(data_rd_bits), .rd_par_err(data_par_err),
    .wr_en, .wr_addr(wr_idx), .wr_bits(wr_data),
    .inj_en(inj_data_en), .inj_addr(inj_index), .inj_mask(inj_mask)
  );
endmodule

// File: tb/test_icache_parity_top.sv
`timescale 1ns/1ps
module test_icache_parity_top;
  localparam int LINES = 16, TAG_W = 31, DATA_W = 72;
  localparam int IDX_W = $clog2(LINES), ADDR_W = TAG_W + IDX_W;

  logic clk = 1'b0, rst = 1'b1;
  logic fetch_req_valid = 1'b0;
  logic [ADDR_W-1:0] fetch_req_addr = '0;
  logic fetch_req_ready, fetch_rsp_valid, refill_req_valid, err_refetch;
  logic [DATA_W-1:0] fetch_rsp_data;
  logic [ADDR_W-1:0] refill_req_addr;
  logic refill_rsp_valid = 1'b0;
  logic [DATA_W-1:0] refill_rsp_data = '0;
  logic inj_valid = 1'b0, inj_target = 1'b0;
  logic [IDX_W-1:0] inj_index = '0;
  logic [DATA_W:0] inj_mask = '0;

  int checks = 0, errors = 0;
  int refill_count = 0;
  logic [ADDR_W-1:0] last_refill_addr = '0;

  always #2 clk = ~clk;

  icache_parity_top i_icache_parity_top (
    .clk, .rst, .fetch_req_valid, .fetch_req_addr, .fetch_req_ready,
    .fetch_rsp_valid, .fetch_rsp_data, .refill_req_valid, .refill_req_addr,
    .refill_rsp_valid, .refill_rsp_data, .inj_valid, .inj_target,
    .inj_index, .inj_mask, .err_refetch
  );

  function automatic logic [DATA_W-1:0] mem_word(logic [ADDR_W-1:0] a);
    return {a[7:0] ^ 8'hA5, a[31:0] * 32'h9E3779B1, ~a[31:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] mk(logic [TAG_W-1:0] t, int idx);
    return {t, idx[IDX_W-1:0]};
  endfunction

  task automatic chk(string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Next memory level: answers each refill request after two more cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (refill_req_valid) begin
        logic [ADDR_W-1:0] a;
        a = refill_req_addr;
        refill_count++;
        last_refill_addr = a;
        repeat (2) @(negedge clk);
        refill_rsp_valid = 1'b1;
        refill_rsp_data  = mem_word(a);
        @(negedge clk);
        refill_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_fetch(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                          output int lat, output int errs, output int reqs);
    int r0;
    bit stall_ok;
    r0 = refill_count;
    @(negedge clk);
    fetch_req_valid = 1'b1;
    fetch_req_addr  = a;
    @(negedge clk);
    fetch_req_valid = 1'b0;
    lat = 1; errs = 0; stall_ok = 1'b1;
    while (!fetch_rsp_valid && lat < 40) begin
      if (fetch_req_ready) stall_ok = 1'b0;
      if (err_refetch) errs++;
      @(negedge clk);
      lat++;
    end
    if (err_refetch) errs++;
    d = fetch_rsp_data;
    reqs = refill_count - r0;
    chk("R9", "ready held low while busy", DATA_W'(stall_ok), DATA_W'(1));
    if (lat >= 40) chk("R2", "response timeout", DATA_W'(lat), DATA_W'(0));
    @(negedge clk);
    chk("R8", "err pulse after response", DATA_W'(err_refetch), DATA_W'(0));
  endtask

  task automatic inject(input logic tgt, input int idx, input logic [DATA_W:0] m);
    @(negedge clk);
    inj_valid = 1'b1; inj_target = tgt; inj_index = idx[IDX_W-1:0]; inj_mask = m;
    @(negedge clk);
    inj_valid = 1'b0; inj_mask = '0;
  endtask

  task automatic expect_miss(string req, logic [ADDR_W-1:0] a, int exp_err);
    logic [DATA_W-1:0] d; int lat, errs, reqs;
    do_fetch(a, d, lat, errs, reqs);
    chk(req, "miss latency", DATA_W'(lat), DATA_W'(5));
    chk(req, "one refill request", DATA_W'(reqs), DATA_W'(1));
    chk(req, "refill address", DATA_W'(last_refill_addr), DATA_W'(a));
    chk(req, "refilled word", d, mem_word(a));
    chk(req, "err pulse count", DATA_W'(errs), DATA_W'(exp_err));
  endtask

  task automatic expect_hit(string req, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] d; int lat, errs, reqs;
    do_fetch(a, d, lat, errs, reqs);
    chk(req, "hit latency", DATA_W'(lat), DATA_W'(2));
    chk(req, "no refill on hit", DATA_W'(reqs), DATA_W'(0));
    chk(req, "no err on hit", DATA_W'(errs), DATA_W'(0));
    chk(req, "hit word", d, exp);
  endtask

  task automatic t_reset;
    chk("R1", "ready after reset", DATA_W'(fetch_req_ready), DATA_W'(1));
    chk("R1", "rsp_valid after reset", DATA_W'(fetch_rsp_valid), DATA_W'(0));
    chk("R1", "refill_req after reset", DATA_W'(refill_req_valid), DATA_W'(0));
    chk("R1", "err after reset", DATA_W'(err_refetch), DATA_W'(0));
  endtask

  task automatic t_fill_and_hit;
    for (int i = 0; i < LINES; i++) expect_miss("R1_R4_R5", mk(31'h1000 + i * 7, i), 0);
    for (int i = 0; i < LINES; i++) expect_hit("R2_R3", mk(31'h1000 + i * 7, i), mem_word(mk(31'h1000 + i * 7, i)));
    // conflict miss: same index, other tag, then original tag misses again
    expect_miss("R4", mk(31'h7ABCDEF, 3), 0);
    expect_hit("R5", mk(31'h7ABCDEF, 3), mem_word(mk(31'h7ABCDEF, 3)));
    expect_miss("R4", mk(31'h1000 + 21, 3), 0);
  endtask

  task automatic t_tag_error;
    logic [ADDR_W-1:0] a;
    a = mk(31'h1000 + 35, 5);
    inject(1'b0, 5, 73'(1) << 5);
    expect_miss("R6", a, 1);
    expect_hit("R6", a, mem_word(a));
    inject(1'b0, 5, 73'(1) << TAG_W);   // parity bit only
    expect_miss("R13", a, 1);
    expect_hit("R13", a, mem_word(a));
  endtask

  task automatic t_data_error;
    logic [ADDR_W-1:0] a;
    a = mk(31'h1000 + 42, 6);
    inject(1'b1, 6, 73'(1) << 40);
    expect_miss("R7", a, 1);
    expect_hit("R7", a, mem_word(a));
    inject(1'b1, 6, 73'(1) << DATA_W);  // parity bit only
    expect_miss("R13", a, 1);
    expect_hit("R13", a, mem_word(a));
  endtask

  task automatic t_double;
    logic [ADDR_W-1:0] a;
    logic [DATA_W:0] m;
    a = mk(31'h1000 + 63, 9);
    m = (73'(1) << 3) | (73'(1) << 9);
    inject(1'b1, 9, m);
    expect_hit("R10", a, mem_word(a) ^ m[DATA_W-1:0]);
  endtask

  task automatic t_multi;
    logic [ADDR_W-1:0] a, b, c;
    a = mk(31'h1000 + 70, 10); b = mk(31'h1000 + 77, 11); c = mk(31'h1000 + 84, 12);
    inject(1'b0, 10, 73'(1) << 17);
    inject(1'b1, 11, 73'(1) << 66);
    expect_miss("R11", a, 1);
    expect_hit("R11", c, mem_word(c));
    expect_miss("R11", b, 1);
    expect_hit("R11", a, mem_word(a));
    expect_hit("R11", b, mem_word(b));
  endtask

  task automatic t_stray;
    logic [ADDR_W-1:0] a;
    int seen;
    a = mk(31'h1000 + 91, 13);
    seen = 0;
    @(negedge clk);
    refill_rsp_valid = 1'b1;
    refill_rsp_data  = 72'hDEAD_BEEF_0123_4567_89;
    @(negedge clk);
    refill_rsp_valid = 1'b0;
    if (fetch_rsp_valid) seen++;
    @(negedge clk);
    if (fetch_rsp_valid) seen++;
    chk("R12", "no response to stray refill", DATA_W'(seen), DATA_W'(0));
    expect_hit("R12", a, mem_word(a));
    expect_hit("R12", mk(31'h1000, 0), mem_word(mk(31'h1000, 0)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill_and_hit();
    t_tag_error();
    t_data_error();
    t_double();
    t_multi();
    t_stray();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule